// File: doc/BRIEF.md
# Serial Grant Chain Bus Arbiter

This block decides which of several potential masters may drive a shared bus. A central arbiter sees only one combined request line, formed as the OR of every device's request, and drives a single grant into a chain of cells, one cell per device. The grant enters at the first cell and moves one cell further each clock. A cell that holds the grant while its device is requesting keeps it. A cell whose device is not requesting hands the grant on to the next cell.

Priority therefore comes only from position: the cell nearest the arbiter wins every contest. The block gives no fairness, so a device near the arbiter that keeps requesting starves every device further down the chain. A device owns the bus from the cycle it captures the grant until any agent pulses the shared release line. After a release the arbiter holds the grant low for at least one cycle before it starts a new round.

Top module: `daisy_arbiter`

## Requirements
- R1: While reset is active, and in the first cycle after it, `own_o` is all zero and `grant_o` is low.
- R2: The arbiter raises `grant_o` only in the cycle after some request was sampled while the bus had no owner. If every request drops before any device captures the grant, `grant_o` falls on the next edge.
- R3: Suppose the bus is idle and a single device at chain position k (1 is the position nearest the arbiter, and it is bit 0 of `req_i` and `own_o`) has its request sampled at edge E. Then `grant_o` is high after E, and `own_o` bit k-1 rises after edge E+k+1.
- R4: When several devices request at the same time, the one at the lowest position becomes the owner.
- R5: At most one bit of `own_o` is set at any time.
- R6: An owner keeps ownership after its request drops, until the release line is sampled high.
- R7: A sampled release clears `own_o` on the same edge. `grant_o` then stays low for at least the following cycle, and a new grant follows one cycle later if requests are pending.
- R8: A device that withdraws its request before it captures the grant lets the grant pass on. A lower device that is still requesting then gains ownership with the same latency it would have if it requested alone.
- R9: A release pulse while no device owns the bus has no effect: a grant in flight still reaches its requester on time, and a later request sees the normal latency.
- R10: A device at position 1 that keeps requesting wins again after each release, ahead of any lower requester.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N_DEV | Per-device bus request; bit 0 is chain position 1 |
| release_i | input | 1 | Shared release line, pulsed by the owner when it is done |
| grant_o | output | 1 | Grant that the arbiter drives into the chain entry |
| own_o | output | N_DEV | Per-device bus-owned indication |

## Verification
The bench drives a lone requester far down the chain to measure the ripple latency. It drives simultaneous requesters at two positions to show that position alone picks the winner. It drives a persistent requester at position 1 to show that it wins again over a waiting lower device. Requests withdrawn before capture, both by a higher device and by every device, show whether the grant moves on or the round is abandoned. Release pulses with no owner and during an in-flight grant show that release only affects an existing owner. After each release the bench checks the one-cycle grant gap.

// File: rtl/daisy_arb_pkg.sv
package daisy_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRANT = 2'd1,
    ST_BUSY  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/daisy_arb_fsm.sv
module daisy_arb_fsm
  import daisy_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_req_i,
  input  logic capture_i,
  input  logic release_i,
  output logic grant_o,
  output logic busy_o
);
  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (bus_req_i) state_d = ST_GRANT;
      ST_GRANT: if (capture_i) state_d = ST_BUSY;
                else if (!bus_req_i) state_d = ST_IDLE;
      ST_BUSY:  if (release_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign grant_o = (state_q == ST_GRANT);
  assign busy_o  = (state_q == ST_BUSY);

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_o) |-> $past(bus_req_i)); // R2
  AST_RELEASE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && release_i) |=> !grant_o); // R7
endmodule

// File: rtl/daisy_chain_cell.sv
module daisy_chain_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arb_grant_i,
  input  logic grant_in_i,
  input  logic req_i,
  input  logic release_i,
  input  logic block_i,
  output logic grant_out_o,
  output logic block_o,
  output logic capture_o,
  output logic own_o
);
  logic held_q, own_q, take;

  // one register per stage: grant ripples one cell per cycle, cleared when arbiter drops it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= 1'b0;
    else         held_q <= grant_in_i & arb_grant_i;
  end

  assign take        = held_q & arb_grant_i & req_i & ~block_i;
  assign grant_out_o = held_q & ~req_i;
  assign block_o     = block_i | take;
  assign capture_o   = take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 own_q <= 1'b0;
    else if (own_q && release_i) own_q <= 1'b0;
    else if (take)               own_q <= 1'b1;
  end

  assign own_o = own_q;

  AST_OWNER_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q && !release_i) |=> own_q); // R6
  AST_CAPTURE_NEEDS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(own_q) |-> $past(held_q && req_i)); // R4
endmodule

// File: rtl/daisy_arbiter.sv
module daisy_arbiter #(
  parameter int N_DEV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DEV-1:0] req_i,
  input  logic             release_i,
  output logic             grant_o,
  output logic [N_DEV-1:0] own_o
);
  logic             bus_req, arb_grant, arb_busy, any_own, any_cap;
  logic [N_DEV:0]   pass_w;
  logic [N_DEV:0]   block_w;
  logic [N_DEV-1:0] cap_w;

  assign bus_req    = |req_i;  // wired-OR request line
  assign any_own    = |own_o;
  assign any_cap    = |cap_w;
  assign pass_w[0]  = arb_grant;
  assign block_w[0] = any_own;

  daisy_arb_fsm i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_req_i (bus_req),
    .capture_i (any_cap),
    .release_i (release_i),
    .grant_o   (arb_grant),
    .busy_o    (arb_busy)
  );

  for (genvar i = 0; i < N_DEV; i++) begin : g_cell
    daisy_chain_cell i_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .arb_grant_i (arb_grant),
      .grant_in_i  (pass_w[i]),
      .req_i       (req_i[i]),
      .release_i   (release_i),
      .block_i     (block_w[i]),
      .grant_out_o (pass_w[i+1]),
      .block_o     (block_w[i+1]),
      .capture_o   (cap_w[i]),
      .own_o       (own_o[i])
    );
  end

  assign grant_o = arb_grant;

  AST_ONE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(own_o)); // R5
  AST_RELEASE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_busy && release_i) |=> (own_o == '0)); // R7
  AST_OWNER_MEANS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_o != '0) |-> !grant_o); // R2
endmodule

// File: tb/test_daisy_arbiter.sv
module test_daisy_arbiter;
  localparam int N = 4;

  typedef struct {
    int         cyc;
    logic [N-1:0] own;
    logic       grant;
    string      tag;
  } exp_t;

  logic clk_i = 1'b0, rst_ni = 1'b0, release_i = 1'b0;
  logic [N-1:0] req_i = '0;
  logic grant_o;
  logic [N-1:0] own_o;
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;
  exp_t q[$];

  always #10 clk_i = ~clk_i;  // 50 MHz
  always @(posedge clk_i) cyc <= cyc + 1;

  daisy_arbiter #(.N_DEV(N)) i_daisy_arbiter (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i),
    .release_i(release_i), .grant_o(grant_o), .own_o(own_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic expect_at(input int d, input logic [N-1:0] own, input logic g, input string tag);
    exp_t e;
    e.cyc = cyc + d; e.own = own; e.grant = g; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check_now(input logic [N-1:0] own, input logic g, input string tag);
    checks++;
    if (own_o !== own || grant_o !== g) begin
      fails++;
      $display("FAIL %s: own=%b grant=%b expected own=%b grant=%b", tag, own_o, grant_o, own, g);
    end
  endtask

  task automatic cleanup();
    req_i = '0; release_i = 1'b1; step(1);
    release_i = 1'b0; step(2);
  endtask

  // monitor: pops expected items at their cycle
  always @(negedge clk_i) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      check_now(q[0].own, q[0].grant, q[0].tag);
      void'(q.pop_front());
    end
  end

  initial begin
    step(2);
    check_now('0, 1'b0, "R1 in reset");
    rst_ni = 1'b1;
    step(1);
    check_now('0, 1'b0, "R1 after reset");

    // lone requester at position 3
    req_i = 4'b0100;
    expect_at(1, '0, 1'b1, "R2 grant");
    expect_at(4, '0, 1'b1, "R3 not yet");
    expect_at(5, 4'b0100, 1'b0, "R3 own");
    step(5);
    req_i = '0;
    expect_at(3, 4'b0100, 1'b0, "R6 hold");
    step(3);
    release_i = 1'b1; step(1); release_i = 1'b0;
    expect_at(1, '0, 1'b0, "R7 cleared");
    step(2);

    // simultaneous positions 2 and 4
    req_i = 4'b1010;
    expect_at(4, 4'b0010, 1'b0, "R4 priority");
    step(4);
    cleanup();

    // persistent position 1 against position 2
    req_i = 4'b0011;
    expect_at(3, 4'b0001, 1'b0, "R4 first");
    step(3);
    release_i = 1'b1; step(1); release_i = 1'b0;
    check_now('0, 1'b0, "R7 gap");
    expect_at(1, '0, 1'b1, "R7 regrant");
    expect_at(3, 4'b0001, 1'b0, "R10 starve");
    step(3);
    cleanup();

    // higher device withdraws before capture
    req_i = 4'b0011;
    step(1);
    req_i = 4'b0010;
    expect_at(2, '0, 1'b1, "R8 in flight");
    expect_at(3, 4'b0010, 1'b0, "R8 passed on");
    step(3);
    cleanup();

    // release with no owner
    release_i = 1'b1; step(1); release_i = 1'b0;
    expect_at(1, '0, 1'b0, "R9 idle release");
    step(1);
    req_i = 4'b0001;
    expect_at(3, 4'b0001, 1'b0, "R9 latency");
    step(3);
    cleanup();

    // release while grant travels
    req_i = 4'b1000;
    step(2);
    release_i = 1'b1; step(1); release_i = 1'b0;
    expect_at(3, 4'b1000, 1'b0, "R9 in-flight release");
    step(3);
    cleanup();

    // all requests drop before capture
    req_i = 4'b1000;
    step(1);
    req_i = '0;
    expect_at(1, '0, 1'b0, "R2 abandon");
    expect_at(5, '0, 1'b0, "R2 no owner");
    step(6);

    while (q.size() > 0) step(1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule